// File: doc/BRIEF.md
# Key-on wakeup interrupt detector

This block watches an eight-line key port and raises a single interrupt request when one of the enabled key lines is pulled low. A line is enabled when its direction bit marks it as an input. Lines configured as outputs are forced high and never take part. The enabled lines are combined into one level by a wide AND. The block detects a falling edge on that combined level, so a key held down hides presses on every other enabled key until it is released.

The combined level passes through a two-flop synchronizer before the edge detector. A detected fall sets a request flag, which stays set until software pulses the clear strobe. A group-wide pull-up select makes undriven input lines read high.

For low-power operation, a wakeup output is formed without any clocked logic. It is driven from the combined level and the low-power indication, so it can end stop mode while the clock is halted.

Top module: `keyon_wake_detect`

## Requirements
- R1: A key line whose direction bit is 1 (output) is treated as high and cannot cause a request. A direction bit of 0 makes the line an input that takes part in detection.
- R2: When the AND of all enabled, effective key levels goes from 1 to 0, `irq_flag` rises. It is visible after the third rising clock edge following the change, and not after the second.
- R3: While any enabled line is held low, a fall on another enabled line sets no new request.
- R4: `irq_flag` stays high until `irq_clr` is sampled high at a rising edge with no new fall in that cycle; it reads 0 after that edge.
- R5: If a new fall and `irq_clr` occur in the same cycle, `irq_flag` stays high.
- R6: With `pullup_en` = 1, an input line whose `key_undriven` bit is 1 reads high whatever `key_pin` shows. With `pullup_en` = 0, the raw `key_pin` value is used.
- R7: `wake` is 1 exactly when `lowpow` is 1 and some enabled line is effectively low. It follows the inputs with no clock running.
- R8: During and right after reset, `irq_flag` is 0. With all lines high, leaving reset produces no request.
- R9: A rise of the combined level (release of all keys) produces no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for synchronizer, edge detector and flag |
| rst_n | input | 1 | Active-low asynchronous reset |
| key_pin | input | 8 | Raw key line levels |
| key_dir | input | 8 | Per-line direction, 1 = output (masked), 0 = input |
| key_undriven | input | 8 | Per-line flag that the pad is not driven externally |
| pullup_en | input | 1 | Group pull-up select for undriven input lines |
| lowpow | input | 1 | High while the system is in wait or stop mode |
| irq_clr | input | 1 | One-cycle request clear strobe |
| irq_flag | output | 1 | Latched interrupt request |
| wake | output | 1 | Combinational wakeup request |

## Verification
A table of key patterns is tried, each starting from all lines high. The patterns differ in direction masks, which lines are pulled low, and whether the pull-up covers an undriven pad. Together they tell a masked output line apart from a live input, and a pulled-up floating pad apart from a raw low one. Directed sequences then hold one key while pressing another, which separates combined-level detection from per-line detection. They also collide a fall with the clear strobe. Finally, the clock is stopped before the wakeup output is checked, which shows that `wake` needs no clock edge.

// File: rtl/keyon_wake_detect.sv
module keyon_wake_detect #(
  parameter int NKEY = 8,
  parameter int SYNC = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NKEY-1:0] key_pin,
  input  logic [NKEY-1:0] key_dir,
  input  logic [NKEY-1:0] key_undriven,
  input  logic            pullup_en,
  input  logic            lowpow,
  input  logic            irq_clr,
  output logic            irq_flag,
  output logic            wake
);

  logic [NKEY-1:0] lvl;
  logic            comb_lvl;
  logic [SYNC-1:0] sync_q;
  logic            prev_q;
  logic            fall;

  assign lvl      = key_dir | key_pin | ({NKEY{pullup_en}} & key_undriven);
  assign comb_lvl = &lvl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '1;
      prev_q <= 1'b1;
    end else begin
      sync_q <= {sync_q[SYNC-2:0], comb_lvl};
      prev_q <= sync_q[SYNC-1];
    end
  end

  assign fall = prev_q & ~sync_q[SYNC-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       irq_flag <= 1'b0;
    else if (fall)    irq_flag <= 1'b1;
    else if (irq_clr) irq_flag <= 1'b0;
  end

  assign wake = lowpow & ~comb_lvl;

  assert_fall_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
    fall |=> irq_flag);

  assert_edge_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (fall && irq_clr) |=> irq_flag);

  assert_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_clr && !fall) |=> !irq_flag);

  assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_flag && !irq_clr) |=> irq_flag);

  assert_no_spurious_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_flag && !fall) |=> !irq_flag);

endmodule

// File: tb/keyon_wake_detect_bench.sv
module keyon_wake_detect_bench;

  logic       clk = 1'b0;
  logic       clk_en = 1'b1;
  logic       rst_n = 1'b0;
  logic [7:0] key_pin = 8'hFF;
  logic [7:0] key_dir = 8'h00;
  logic [7:0] key_undriven = 8'h00;
  logic       pullup_en = 1'b0;
  logic       lowpow = 1'b0;
  logic       irq_clr = 1'b0;
  logic       irq_flag;
  logic       wake;

  int errors = 0;
  int checks = 0;

  always #5 clk = clk_en ? ~clk : clk;

  keyon_wake_detect u_keyon_wake_detect (
    .clk(clk), .rst_n(rst_n), .key_pin(key_pin), .key_dir(key_dir),
    .key_undriven(key_undriven), .pullup_en(pullup_en), .lowpow(lowpow),
    .irq_clr(irq_clr), .irq_flag(irq_flag), .wake(wake)
  );

  // {dir, pin, undriven, pullup, expected irq}
  localparam logic [25:0] VEC [8] = '{
    {8'h00, 8'hFE, 8'h00, 1'b0, 1'b1},
    {8'h01, 8'hFE, 8'h00, 1'b0, 1'b0},
    {8'h80, 8'h7F, 8'h00, 1'b0, 1'b0},
    {8'h80, 8'h7E, 8'h00, 1'b0, 1'b1},
    {8'h00, 8'hFE, 8'h01, 1'b1, 1'b0},
    {8'h00, 8'hFE, 8'h01, 1'b0, 1'b1},
    {8'hFF, 8'h00, 8'h00, 1'b0, 1'b0},
    {8'h00, 8'h00, 8'hFF, 1'b0, 1'b1}
  };

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic cycles(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle_and_clear();
    @(negedge clk);
    key_pin = 8'hFF; key_dir = 8'h00; key_undriven = 8'h00; pullup_en = 1'b0;
    cycles(4);
    irq_clr = 1'b1;
    cycles(1);
    irq_clr = 1'b0;
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #1;
    check("R8 in reset", irq_flag, 1'b0);
    cycles(2);
    rst_n = 1'b1;
    cycles(5);
    check("R8 after reset", irq_flag, 1'b0);
    check("R7 idle wake", wake, 1'b0);

    for (int i = 0; i < 8; i++) begin
      idle_and_clear();
      {key_dir, key_pin, key_undriven, pullup_en} = VEC[i][25:1];
      cycles(4);
      check($sformatf("R1/R2/R6 vector %0d", i), irq_flag, VEC[i][0]);
    end

    // R2 latency
    idle_and_clear();
    key_pin = 8'hEF;
    cycles(2);
    check("R2 not yet after two edges", irq_flag, 1'b0);
    cycles(1);
    check("R2 set after third edge", irq_flag, 1'b1);

    // R4 hold and clear
    cycles(5);
    check("R4 holds", irq_flag, 1'b1);
    irq_clr = 1'b1;
    cycles(1);
    irq_clr = 1'b0;
    check("R4 cleared", irq_flag, 1'b0);

    // R3 second key blocked while first held
    key_pin = 8'hEC;
    cycles(5);
    check("R3 second fall hidden", irq_flag, 1'b0);
    key_pin = 8'hFC;
    cycles(5);
    check("R3 release first still hidden", irq_flag, 1'b0);

    // R9 release all
    key_pin = 8'hFF;
    cycles(5);
    check("R9 rise no request", irq_flag, 1'b0);
    key_pin = 8'hFD;
    cycles(4);
    check("R3 fresh fall after release", irq_flag, 1'b1);

    // R5 fall and clear in same cycle
    key_pin = 8'hFF;
    cycles(4);
    key_pin = 8'h7F;
    cycles(2);
    irq_clr = 1'b1;
    cycles(1);
    irq_clr = 1'b0;
    check("R5 edge wins over clear", irq_flag, 1'b1);
    irq_clr = 1'b1;
    cycles(1);
    irq_clr = 1'b0;
    check("R5 later clear works", irq_flag, 1'b0);

    // R7 wake without clock
    key_pin = 8'hFF;
    cycles(4);
    clk_en = 1'b0;
    #20;
    lowpow = 1'b1;
    #3;
    check("R7 no wake keys high", wake, 1'b0);
    key_pin = 8'hF7;
    #3;
    check("R7 wake with clock stopped", wake, 1'b1);
    check("R7 flag untouched without clock", irq_flag, 1'b0);
    key_dir = 8'h08;
    #3;
    check("R7 masked line no wake", wake, 1'b0);
    key_dir = 8'h00;
    lowpow = 1'b0;
    #3;
    check("R7 no wake when not low power", wake, 1'b0);
    key_pin = 8'hFF;
    #3;
    clk_en = 1'b1;
    cycles(5);
    check("R9 no request after release", irq_flag, 1'b0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule